// File: doc/BRIEF.md
# Chained Transmit Descriptor DMA Engine

This block walks a linked list of transmit descriptors in memory and feeds frame data into a transmit FIFO. Each descriptor is four 32-bit words: a control/status word, a buffer byte count, a buffer address and the address of the next descriptor. A frame may occupy one buffer or a chain of several buffers. A flag in the control word marks the first buffer of a frame, and another flag marks its last buffer. The engine streams each buffer one word per memory read and gives a byte-valid count with every FIFO write. When a buffer in the middle of a frame has been sent, the engine returns that descriptor to software and follows the chain to the next one.

After a frame has been sent, the engine waits for the MAC's completion status. It writes that status back into the descriptor of the frame's last buffer, and it also writes the timestamp when the MAC reports one. In normal mode it waits for this status before it fetches the next descriptor. In second-frame mode it fetches and sends the next frame first, and writes back the earlier frame's status afterwards. If the engine fetches a descriptor it does not own, it suspends until a poll demand arrives. A bus error response stops it and raises a sticky fault. A start pulse launches the engine at a base address and clears the fault.

Top module: `txd_engine`

## Requirements
- R1: After reset the engine is idle, with `memReq`, `fifoWrEn` and `fault` low. A `startReq` pulse makes the next memory request a read of word 0 at `baseAddr`.
- R2: Bit 31 of word 0 is the ownership flag. A fetched descriptor with bit 31 clear suspends the engine, and no memory request is made until `pollDemand`. A poll re-fetches the same descriptor and suspends again if it is still not owned. `pollDemand` has no effect while the engine is not suspended.
- R3: Bit 28 of word 0 flags the first buffer of a frame. The first descriptor of a frame must have bit 28 set, and any following descriptor of the same frame must have it clear. A violation stops the engine and raises `fault`, and no data is written to the FIFO from that descriptor.
- R4: Buffer data goes to the FIFO one word per read, starting at the buffer address (word 2), for the byte count in bits [12:0] of word 1. `fifoBytes` is 4 on full words and the remainder (1 to 3) on a final partial word. `fifoLast` is high only on the final word of the buffer whose descriptor has bit 29 (last-buffer flag) set.
- R5: While `fifoFull` is high, `fifoWrEn` stays low and the word is held, so no data is lost or repeated.
- R6: When a buffer with bit 29 clear has been sent, the engine rewrites its word 0 with bit 31 cleared and all other bits kept. It then fetches the descriptor at the address in word 3.
- R7: The status word is written to word 0 of the frame's last descriptor as `{1'b0, statWord[30:0]}`.
- R8: When the status carries a timestamp (`statTsValid`), `statTsLo` and `statTsHi` are written to words 2 and 3 of that descriptor before the status word. Without a timestamp, words 2 and 3 are left unchanged.
- R9: With `secondFrameMode` low, the engine makes no memory request after a frame's data until that frame's status has arrived.
- R10: With `secondFrameMode` high, the next frame is fetched and sent before the previous frame's status arrives. Write-back for the previous frame waits for that status.
- R11: An error response (`memErr`) to any read or write stops the engine and sets `fault`. `fault` stays high, with no further requests, until the next `startReq`, which clears it.
- R12: A memory request holds its address, direction and write data until `memAck` or `memErr`.
- R13: A status that arrives in the same cycle the engine consumes the previous one is kept and used for the next write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse; begins fetching at `baseAddr` and clears `fault` |
| baseAddr | input | 32 | Byte address of the first descriptor |
| secondFrameMode | input | 1 | 1 = overlap the next frame with pending status |
| pollDemand | input | 1 | Resume pulse for a suspended engine |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address of the access |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with `memAck` |
| memAck | input | 1 | Access completed |
| memErr | input | 1 | Access failed (bus error) |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoData | output | 32 | FIFO write data |
| fifoBytes | output | 3 | Valid bytes in `fifoData` (1 to 4) |
| fifoLast | output | 1 | Final word of a frame |
| fifoFull | input | 1 | FIFO cannot accept a word |
| statValid | input | 1 | One-cycle pulse: frame status available |
| statWord | input | 32 | Frame status |
| statTsValid | input | 1 | Timestamp present with this status |
| statTsLo | input | 32 | Timestamp low word |
| statTsHi | input | 32 | Timestamp high word |
| fault | output | 1 | Sticky stop-on-error indication |

## Verification
The risky overlap is a new status pulse arriving in the same cycle that the engine takes the stored status of the previous frame. In second-frame mode this can happen for two consecutive frames. The bench provokes it by running two frames without any status while the engine waits on the first one, then driving both status pulses on back-to-back cycles. It judges the result by reading each frame's word 0 afterwards: the first descriptor must carry the first status and the second descriptor the second status, with neither lost or duplicated.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int OWN_BIT   = 31;
  localparam int LAST_BIT  = 29;
  localparam int FIRST_BIT = 28;

  typedef enum logic [2:0] {
    OP_NONE, OP_FETCH, OP_READ, OP_CLOSE, OP_TSLO, OP_TSHI, OP_STAT
  } memOp_e;

  // strobes from control to datapath
  typedef struct packed {
    memOp_e     op;
    logic [1:0] idx;
    logic       ldBase;
    logic       advCur;
    logic       ldWord;
    logic       beginBuf;
    logic       stepBuf;
    logic       takeStat;
    logic       adoptPend;
    logic       dropPend;
  } ctrlStrb_t;
endpackage

// File: rtl/txd_dpath.sv
module txd_dpath
  import txd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [31:0]       memRdata,
  input  logic              statValid,
  input  logic [31:0]       statWord,
  input  logic              statTsValid,
  input  logic [31:0]       statTsLo,
  input  logic [31:0]       statTsHi,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [31:0]       fifoData,
  output logic [2:0]        fifoBytes,
  output logic              fifoLast,
  output logic              dOwn,
  output logic              dFirst,
  output logic              dLast,
  output logic              cntZero,
  output logic              lastWord,
  output logic              pendValid,
  output logic              statPend,
  output logic              capTs
);
  localparam logic [CNT_W-1:0]  WORD_BYTES = CNT_W'(4);
  localparam logic [ADDR_W-1:0] ADDR_STEP  = ADDR_W'(4);

  logic [ADDR_W-1:0] curAddr, bufPtr, nextAddr, pendAddr;
  logic [31:0]       ctlWord, dataLatch;
  logic [CNT_W-1:0]  byteCnt, remain;
  logic              pendQ;
  logic [31:0]       capStat, capLo, capHi, wbStat, wbLo, wbHi;
  logic              capTsQ, capPendQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0; bufPtr <= '0; nextAddr <= '0; pendAddr <= '0;
      ctlWord <= '0; dataLatch <= '0; byteCnt <= '0; remain <= '0;
      pendQ <= 1'b0;
    end else begin
      if (strb.ldBase) begin
        curAddr <= baseAddr;
        pendQ   <= 1'b0;
      end
      if (strb.advCur) curAddr <= nextAddr;
      if (strb.ldWord) begin
        if (strb.op == OP_READ) dataLatch <= memRdata;
        else begin
          case (strb.idx)
            2'd0: ctlWord  <= memRdata;
            2'd1: byteCnt  <= memRdata[CNT_W-1:0];
            2'd2: bufPtr   <= memRdata[ADDR_W-1:0];
            default: nextAddr <= memRdata[ADDR_W-1:0];
          endcase
        end
      end
      if (strb.beginBuf) remain <= byteCnt;
      if (strb.stepBuf) begin
        bufPtr <= bufPtr + ADDR_STEP;
        remain <= lastWord ? '0 : remain - WORD_BYTES;
      end
      if (strb.adoptPend) begin
        pendAddr <= curAddr;
        pendQ    <= 1'b1;
      end else if (strb.dropPend) pendQ <= 1'b0;
    end
  end

  // one capture stage for MAC status; a new arrival wins over consumption
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capStat <= '0; capLo <= '0; capHi <= '0; capTsQ <= 1'b0; capPendQ <= 1'b0;
      wbStat <= '0; wbLo <= '0; wbHi <= '0;
    end else begin
      if (strb.takeStat) begin
        wbStat <= capStat; wbLo <= capLo; wbHi <= capHi;
      end
      if (statValid) begin
        capStat  <= statWord;
        capLo    <= statTsLo;
        capHi    <= statTsHi;
        capTsQ   <= statTsValid;
        capPendQ <= 1'b1;
      end else if (strb.takeStat) capPendQ <= 1'b0;
    end
  end

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    case (strb.op)
      OP_FETCH: memAddr = curAddr + ADDR_W'({strb.idx, 2'b00});
      OP_READ:  memAddr = bufPtr;
      OP_CLOSE: begin
        memAddr  = curAddr;
        memWdata = ctlWord & ~(32'd1 << OWN_BIT);
      end
      OP_TSLO: begin
        memAddr  = pendAddr + ADDR_W'(8);
        memWdata = wbLo;
      end
      OP_TSHI: begin
        memAddr  = pendAddr + ADDR_W'(12);
        memWdata = wbHi;
      end
      OP_STAT: begin
        memAddr  = pendAddr;
        memWdata = {1'b0, wbStat[30:0]};
      end
      default: ;
    endcase
  end

  assign lastWord  = (remain <= WORD_BYTES);
  assign fifoBytes = lastWord ? remain[2:0] : 3'd4;
  assign fifoData  = dataLatch;
  assign fifoLast  = dLast && lastWord;
  assign dOwn      = ctlWord[OWN_BIT];
  assign dFirst    = ctlWord[FIRST_BIT];
  assign dLast     = ctlWord[LAST_BIT];
  assign cntZero   = (byteCnt == '0);
  assign pendValid = pendQ;
  assign statPend  = capPendQ;
  assign capTs     = capTsQ;
endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
  import txd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      pollDemand,
  input  logic      secondFrameMode,
  input  logic      memAck,
  input  logic      memErr,
  input  logic      fifoFull,
  input  logic      dOwn,
  input  logic      dFirst,
  input  logic      dLast,
  input  logic      cntZero,
  input  logic      lastWord,
  input  logic      pendValid,
  input  logic      statPend,
  input  logic      capTs,
  output ctrlStrb_t strb,
  output logic      memReq,
  output logic      memWe,
  output logic      fifoWrEn,
  output logic      fault
);
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CHECK, S_READ, S_PUSH, S_BUFEND, S_CLOSE, S_FEND,
    S_ADOPT, S_WAITST, S_WBLO, S_WBHI, S_WBST, S_SUSP, S_HALT
  } state_e;
  typedef enum logic [1:0] {C_ADOPT, C_NEXT, C_SUSP} wbCtx_e;

  state_e     state, nState;
  wbCtx_e     ctxQ, nCtx;
  logic [1:0] idxQ, nIdx;
  logic       inFrameQ, nInFrame, faultQ, nFault;
  logic       busDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; ctxQ <= C_NEXT; idxQ <= '0; inFrameQ <= 1'b0; faultQ <= 1'b0;
    end else begin
      state <= nState; ctxQ <= nCtx; idxQ <= nIdx; inFrameQ <= nInFrame; faultQ <= nFault;
    end
  end

  always_comb begin
    strb     = '0;
    nState   = state;
    nCtx     = ctxQ;
    nIdx     = idxQ;
    nInFrame = inFrameQ;
    nFault   = faultQ;
    fifoWrEn = 1'b0;
    busDone  = memAck && !memErr;
    case (state)
      S_IDLE, S_HALT: if (startReq) begin
        strb.ldBase = 1'b1;
        nIdx = '0; nInFrame = 1'b0; nFault = 1'b0;
        nState = S_FETCH;
      end
      S_FETCH: begin
        strb.op = OP_FETCH; strb.idx = idxQ;
        if (busDone) begin
          strb.ldWord = 1'b1;
          nIdx = idxQ + 2'd1;
          if (idxQ == 2'd3) nState = S_CHECK;
        end
      end
      S_CHECK: begin
        if (!dOwn) begin
          if (pendValid) begin nCtx = C_SUSP; nState = S_WAITST; end
          else nState = S_SUSP;
        end else if (inFrameQ == dFirst) begin
          nFault = 1'b1; nState = S_HALT;
        end else begin
          strb.beginBuf = 1'b1;
          nInFrame = 1'b1;
          nState = cntZero ? S_BUFEND : S_READ;
        end
      end
      S_READ: begin
        strb.op = OP_READ;
        if (busDone) begin strb.ldWord = 1'b1; nState = S_PUSH; end
      end
      S_PUSH: if (!fifoFull) begin
        fifoWrEn = 1'b1;
        strb.stepBuf = 1'b1;
        nState = lastWord ? S_BUFEND : S_READ;
      end
      S_BUFEND: if (dLast) begin nInFrame = 1'b0; nState = S_FEND; end
                else nState = S_CLOSE;
      S_CLOSE: begin
        strb.op = OP_CLOSE;
        if (busDone) begin strb.advCur = 1'b1; nState = S_FETCH; end
      end
      S_FEND: if (pendValid) begin nCtx = C_ADOPT; nState = S_WAITST; end
              else nState = S_ADOPT;
      S_ADOPT: begin
        strb.adoptPend = 1'b1;
        if (secondFrameMode) begin strb.advCur = 1'b1; nState = S_FETCH; end
        else begin nCtx = C_NEXT; nState = S_WAITST; end
      end
      S_WAITST: if (statPend) begin
        strb.takeStat = 1'b1;
        nState = capTs ? S_WBLO : S_WBST;
      end
      S_WBLO: begin
        strb.op = OP_TSLO;
        if (busDone) nState = S_WBHI;
      end
      S_WBHI: begin
        strb.op = OP_TSHI;
        if (busDone) nState = S_WBST;
      end
      S_WBST: begin
        strb.op = OP_STAT;
        if (busDone) begin
          strb.dropPend = 1'b1;
          case (ctxQ)
            C_ADOPT: nState = S_ADOPT;
            C_NEXT:  begin strb.advCur = 1'b1; nState = S_FETCH; end
            default: nState = S_SUSP;
          endcase
        end
      end
      S_SUSP: if (pollDemand) nState = S_FETCH;
      default: nState = S_IDLE;
    endcase
    if (strb.op != OP_NONE && memErr) begin
      nFault = 1'b1;
      nState = S_HALT;
    end
  end

  assign memReq = (strb.op != OP_NONE);
  assign memWe  = (strb.op == OP_CLOSE) || (strb.op == OP_TSLO) ||
                  (strb.op == OP_TSHI)  || (strb.op == OP_STAT);
  assign fault  = faultQ;
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              secondFrameMode,
  input  logic              pollDemand,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  input  logic              memErr,
  output logic              fifoWrEn,
  output logic [31:0]       fifoData,
  output logic [2:0]        fifoBytes,
  output logic              fifoLast,
  input  logic              fifoFull,
  input  logic              statValid,
  input  logic [31:0]       statWord,
  input  logic              statTsValid,
  input  logic [31:0]       statTsLo,
  input  logic [31:0]       statTsHi,
  output logic              fault
);
  ctrlStrb_t strb;
  logic dOwn, dFirst, dLast, cntZero, lastWord, pendValid, statPend, capTs;

  txd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pollDemand(pollDemand),
    .secondFrameMode(secondFrameMode), .memAck(memAck), .memErr(memErr),
    .fifoFull(fifoFull), .dOwn(dOwn), .dFirst(dFirst), .dLast(dLast),
    .cntZero(cntZero), .lastWord(lastWord), .pendValid(pendValid),
    .statPend(statPend), .capTs(capTs), .strb(strb), .memReq(memReq),
    .memWe(memWe), .fifoWrEn(fifoWrEn), .fault(fault)
  );

  txd_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .baseAddr(baseAddr),
    .memRdata(memRdata), .statValid(statValid), .statWord(statWord),
    .statTsValid(statTsValid), .statTsLo(statTsLo), .statTsHi(statTsHi),
    .memAddr(memAddr), .memWdata(memWdata), .fifoData(fifoData),
    .fifoBytes(fifoBytes), .fifoLast(fifoLast), .dOwn(dOwn), .dFirst(dFirst),
    .dLast(dLast), .cntZero(cntZero), .lastWord(lastWord),
    .pendValid(pendValid), .statPend(statPend), .capTs(capTs)
  );
endmodule

// File: rtl/txd_engine_chk.sv
module txd_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic              memAck,
  input logic              memErr,
  input logic              fifoWrEn,
  input logic [2:0]        fifoBytes,
  input logic              fifoFull,
  input logic              fault
);
  p_req_held_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !memErr) |=>
      (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  p_no_push_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !fifoWrEn);

  p_bytes_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> (fifoBytes >= 3'd1 && fifoBytes <= 3'd4));

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!memReq && !fifoWrEn));

  p_fault_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (fault && !startReq) |=> fault);

  p_err_stops_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memErr && !startReq) |=> (fault && !memReq));
endmodule

bind txd_engine txd_engine_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/txd_engine_tb.sv
module txd_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] baseAddr = '0;
  logic        secondFrameMode = 1'b0;
  logic        pollDemand = 1'b0;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0, memErr = 1'b0;
  logic        fifoWrEn, fifoLast;
  logic [31:0] fifoData;
  logic [2:0]  fifoBytes;
  logic        fifoFull = 1'b0;
  logic        statValid = 1'b0, statTsValid = 1'b0;
  logic [31:0] statWord = '0, statTsLo = '0, statTsHi = '0;
  logic        fault;

  txd_engine dut_i (.*);

  always #2 clk = ~clk;

  logic [31:0] mem [0:255];
  logic [31:0] fLogD [0:63];
  logic [2:0]  fLogB [0:63];
  logic        fLogL [0:63];
  int          fN = 0, nChk = 0, nFail = 0, fullViol = 0, holdViol = 0;
  logic        errArm = 1'b0, fullPat = 1'b0, holdPrev = 1'b0;
  logic [31:0] errAddr = '0, prevAddr = '0;

  // memory responder and FIFO back-pressure
  always @(negedge clk) begin
    if (memAck || memErr) begin
      memAck <= 1'b0; memErr <= 1'b0;
    end else if (memReq) begin
      if (errArm && memAddr == errAddr) memErr <= 1'b1;
      else memAck <= 1'b1;
      memRdata <= mem[memAddr[9:2]];
    end
    fifoFull <= fullPat ? ~fifoFull : 1'b0;
  end

  // write sink, FIFO log, request stability monitor
  always @(posedge clk) begin
    if (memReq && memAck && memWe && !memErr) mem[memAddr[9:2]] <= memWdata;
    if (fifoWrEn) begin
      if (fifoFull) fullViol++;
      if (fN < 64) begin
        fLogD[fN] = fifoData; fLogB[fN] = fifoBytes; fLogL[fN] = fifoLast;
      end
      fN++;
    end
    if (rstN && holdPrev && (!memReq || memAddr != prevAddr)) holdViol++;
    holdPrev = rstN && memReq && !memAck && !memErr;
    prevAddr = memAddr;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; errArm = 1'b0; fullPat = 1'b0; secondFrameMode = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    fN = 0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic putDesc(input int a, input logic [31:0] w0, w1, w2, w3);
    mem[a >> 2] = w0; mem[(a >> 2) + 1] = w1; mem[(a >> 2) + 2] = w2; mem[(a >> 2) + 3] = w3;
  endtask

  task automatic startAt(input logic [31:0] a);
    @(negedge clk); startReq = 1'b1; baseAddr = a;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic waitFifo(input int n);
    for (int i = 0; i < 2000 && fN < n; i++) @(negedge clk);
  endtask

  task automatic sendStat(input logic [31:0] w, input logic tv, input logic [31:0] lo, hi);
    @(negedge clk); statValid = 1'b1; statWord = w; statTsValid = tv; statTsLo = lo; statTsHi = hi;
    @(negedge clk); statValid = 1'b0;
  endtask

  task automatic tReset();
    doReset();
    chk("R1", "memReq after reset", 32'(memReq), 0);
    chk("R1", "fifoWrEn after reset", 32'(fifoWrEn), 0);
    chk("R1", "fault after reset", 32'(fault), 0);
  endtask

  // single buffer frame in normal mode, FIFO back-pressure on
  task automatic tSingle();
    putDesc('h100, 32'hB000_0000, 32'd10, 32'h200, 32'h140);
    mem['h200 >> 2] = 32'h0302_0100; mem['h204 >> 2] = 32'h0706_0504; mem['h208 >> 2] = 32'h0B0A_0908;
    fullPat = 1'b1;
    @(negedge clk); startReq = 1'b1; baseAddr = 32'h100;
    @(negedge clk); startReq = 1'b0;
    chk("R1", "first request addr", memAddr, 32'h100);
    chk("R1", "first request is read", 32'({memReq, memWe}), 32'b10);
    waitFifo(3);
    fullPat = 1'b0;
    chk("R4", "word0", fLogD[0], 32'h0302_0100);
    chk("R5", "word2 after stalls", fLogD[2], 32'h0B0A_0908);
    chk("R4", "bytes", {fLogB[0], fLogB[1], fLogB[2]}, {3'd4, 3'd4, 3'd2});
    chk("R4", "last flags", {fLogL[0], fLogL[1], fLogL[2]}, 3'b001);
    chk("R5", "no push while full", fullViol, 0);
    repeat (20) @(negedge clk);
    chk("R9", "no request before status", 32'(memReq), 0);
    chk("R9", "descriptor untouched", mem['h100 >> 2], 32'hB000_0000);
    sendStat(32'hFFFF_0123, 1'b1, 32'hAAAA_0001, 32'hBBBB_0002);
    repeat (40) @(negedge clk);
    chk("R7", "status word", mem['h100 >> 2], 32'h7FFF_0123);
    chk("R8", "timestamp lo", mem['h108 >> 2], 32'hAAAA_0001);
    chk("R8", "timestamp hi", mem['h10C >> 2], 32'hBBBB_0002);
    chk("R2", "suspended on unowned", 32'(memReq), 0);
    chk("R2", "no fault on suspend", 32'(fault), 0);
  endtask

  // poll with descriptor still unowned, then a three buffer chain
  task automatic tChain();
    @(negedge clk); pollDemand = 1'b1; @(negedge clk); pollDemand = 1'b0;
    repeat (30) @(negedge clk);
    chk("R2", "still suspended after poll", 32'(memReq), 0);
    chk("R2", "no data while suspended", fN, 3);
    putDesc('h140, 32'h9000_0055, 32'd6, 32'h240, 32'h180);
    putDesc('h180, 32'h8000_00AA, 32'd4, 32'h260, 32'h1C0);
    putDesc('h1C0, 32'hA000_0000, 32'd3, 32'h280, 32'h100);
    mem['h240 >> 2] = 32'h1111_1111; mem['h244 >> 2] = 32'h2222_2222;
    mem['h260 >> 2] = 32'h3333_3333; mem['h280 >> 2] = 32'h4444_4444;
    @(negedge clk); pollDemand = 1'b1; @(negedge clk); pollDemand = 1'b0;
    waitFifo(7);
    chk("R4", "chain data", fLogD[6], 32'h4444_4444);
    chk("R4", "chain bytes", {fLogB[3], fLogB[4], fLogB[5], fLogB[6]}, {3'd4, 3'd2, 3'd4, 3'd3});
    chk("R4", "chain last", {fLogL[3], fLogL[4], fLogL[5], fLogL[6]}, 4'b0001);
    chk("R6", "first buffer closed", mem['h140 >> 2], 32'h1000_0055);
    chk("R6", "middle buffer closed", mem['h180 >> 2], 32'h0000_00AA);
    sendStat(32'h8000_0042, 1'b0, 32'h0, 32'h0);
    repeat (40) @(negedge clk);
    chk("R7", "chain status", mem['h1C0 >> 2], 32'h0000_0042);
    chk("R8", "no timestamp keeps word2", mem['h1C8 >> 2], 32'h280);
  endtask

  // second-frame mode with colliding status pulses
  task automatic tSecond();
    doReset();
    secondFrameMode = 1'b1;
    putDesc('h100, 32'hB000_0000, 32'd4, 32'h200, 32'h110);
    putDesc('h110, 32'hB000_0000, 32'd5, 32'h220, 32'h120);
    mem['h200 >> 2] = 32'hAAAA_5555; mem['h220 >> 2] = 32'hCAFE_F00D; mem['h224 >> 2] = 32'h0000_00EE;
    startAt(32'h100);
    waitFifo(3);
    repeat (10) @(negedge clk);
    chk("R10", "both frames sent early", fN, 3);
    chk("R10", "second frame data", fLogD[2], 32'h0000_00EE);
    chk("R10", "first still owned", mem['h100 >> 2], 32'hB000_0000);
    @(negedge clk); statValid = 1'b1; statWord = 32'h0000_0A0A; statTsValid = 1'b0;
    @(negedge clk); statWord = 32'h0000_0B0B;
    @(negedge clk); statValid = 1'b0;
    repeat (60) @(negedge clk);
    chk("R13", "first frame status", mem['h100 >> 2], 32'h0000_0A0A);
    chk("R13", "second frame status", mem['h110 >> 2], 32'h0000_0B0B);
    chk("R2", "suspended after write-back", 32'(memReq), 0);
  endtask

  task automatic tBusErr();
    doReset();
    putDesc('h100, 32'hB000_0000, 32'd8, 32'h200, 32'h110);
    errArm = 1'b1; errAddr = 32'h204;
    startAt(32'h100);
    repeat (30) @(negedge clk);
    chk("R11", "fault set", 32'(fault), 1);
    chk("R11", "one word before error", fN, 1);
    chk("R11", "no request after error", 32'(memReq), 0);
    errArm = 1'b0;
    startAt(32'h100);
    chk("R11", "start clears fault", 32'(fault), 0);
  endtask

  task automatic tFraming();
    doReset();
    putDesc('h100, 32'h8000_0000, 32'd4, 32'h200, 32'h110);
    startAt(32'h100);
    repeat (20) @(negedge clk);
    chk("R3", "missing first flag faults", 32'(fault), 1);
    chk("R3", "no data from bad start", fN, 0);
    doReset();
    putDesc('h100, 32'h9000_0000, 32'd4, 32'h200, 32'h110);
    putDesc('h110, 32'hB000_0000, 32'd4, 32'h220, 32'h120);
    startAt(32'h100);
    repeat (30) @(negedge clk);
    chk("R3", "first flag mid-frame faults", 32'(fault), 1);
    chk("R3", "only first buffer sent", fN, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    tReset();
    tSingle();
    tChain();
    tSecond();
    tBusErr();
    tFraming();
    chk("R12", "request held until response", holdViol, 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule